// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of a memory burst, one address per clock. A one-cycle start pulse loads a start column together with the burst-length code and the order bit from the mode fields. From the next cycle on, the block presents the beats in sequential or interleaved order, or as an endless incrementing run for the full-page setting.

A marker flags the final beat of every bounded burst. A stop input ends a burst early. A new start pulse that arrives during a burst replaces the running burst at once. Length codes with no defined meaning, and the full-page code combined with interleaved order, are run as single-beat bursts and raise an error flag.

Only the low bits inside the aligned burst block move. The column bits above the block keep their start value for the whole burst, except in full-page mode, where all eight bits count.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held low (asynchronous, active low), `seq_valid_o`, `seq_last_o` and `cfg_err_o` are 0 and `seq_col_o` is 0.
- R2: A cycle with `req_start_i` high begins a burst. In the following cycle `seq_valid_o` is 1 and `seq_col_o` equals the start column. The length code and order bit are captured in that same cycle, and later changes to them have no effect on the running burst.
- R3: Length code 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. `seq_last_o` is 1 only on the final beat, and `seq_valid_o` falls in the cycle after that beat.
- R4: With `cfg_intlv_i` = 0 and a bounded length L, the low log2(L) bits start at the start offset, count up by one per beat and wrap modulo L. For example, L = 4 with offset 2 gives 2,3,0,1.
- R5: With `cfg_intlv_i` = 1, beat i carries the start offset XOR i in its low log2(L) bits. For example, L = 8 with offset 3 gives 3,2,1,0,7,6,5,4.
- R6: In a bounded burst, the column bits above the low log2(L) bits equal those of the start column on every beat.
- R7: Code 3'b111 with `cfg_intlv_i` = 0 is full page. The column steps n, n+1, n+2, ... modulo 256 with no end, and `seq_last_o` is never 1.
- R8: `req_stop_i` high without `req_start_i` makes `seq_valid_o` 0 from the next cycle on.
- R9: A start during a running burst restarts the sequence: the next beat is the new start column. When start and stop are high in the same cycle, start wins.
- R10: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `cfg_intlv_i` = 1, run as a one-beat burst with `seq_last_o` = 1 and set `cfg_err_o`. `cfg_err_o` keeps the verdict of the most recent start until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Begin a new burst (also interrupts a running one) |
| req_col_i | input | 8 | Start column of the new burst |
| req_stop_i | input | 1 | End the running burst |
| cfg_len_i | input | 3 | Burst length code |
| cfg_intlv_i | input | 1 | Order: 0 sequential, 1 interleaved |
| seq_col_o | output | 8 | Column address of the current beat |
| seq_valid_o | output | 1 | A beat is presented this cycle |
| seq_last_o | output | 1 | Current beat is the final beat of a bounded burst |
| cfg_err_o | output | 1 | Last accepted start used an undefined mode |

## Verification
Two events can land in the same cycle. The first is the natural final beat of a bounded burst meeting a new start. The second is a stop pulse coinciding with a start.

Directed sequences raise start on the final beat and raise stop together with start. The random phase lets start and stop fall wherever they land in a burst.

In each case the bench expects the new burst's start column in the next cycle with valid kept high. A cycle-by-cycle model built from the requirements judges every cycle of the random run.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   // burst length codes decoded by the sequencer
   typedef enum logic [2:0] {
      LEN_1   = 3'b000,
      LEN_2   = 3'b001,
      LEN_4   = 3'b010,
      LEN_8   = 3'b011,
      LEN_R4  = 3'b100,
      LEN_R5  = 3'b101,
      LEN_R6  = 3'b110,
      LEN_FP  = 3'b111
   } bcs_len_e;

   // decoded burst mode
   typedef struct packed {
      logic       fullpage;
      logic       intlv;
      logic       err;
      logic [1:0] lg;       // log2 of the bounded length
   } bcs_mode_t;

   localparam int unsigned BCS_LG_MAX = 3;

endpackage

// File: rtl/bcs_mode_dec.sv
module bcs_mode_dec
   import bcs_pkg::*;
#(
   parameter bit INTLV_EN = 1'b1
) (
   input  logic [2:0] len_code_i,
   input  logic       intlv_i,
   output bcs_mode_t  mode_o
);

   logic intlv_req;

   generate
      if (INTLV_EN) begin : g_intlv
         assign intlv_req = intlv_i;
      end else begin : g_seq_only
         assign intlv_req = 1'b0;
      end
   endgenerate

   always_comb begin
      mode_o          = '0;
      mode_o.intlv    = intlv_req;
      unique case (bcs_len_e'(len_code_i))
         LEN_1:   mode_o.lg = 2'd0;
         LEN_2:   mode_o.lg = 2'd1;
         LEN_4:   mode_o.lg = 2'd2;
         LEN_8:   mode_o.lg = 2'd3;
         LEN_FP: begin
            if (intlv_i) begin
               mode_o.err   = 1'b1;
               mode_o.intlv = 1'b0;
            end else begin
               mode_o.fullpage = 1'b1;
            end
         end
         default: begin
            mode_o.err   = 1'b1;
            mode_o.intlv = 1'b0;
         end
      endcase
      // an interleave request with the feature removed is an undefined mode
      if (!INTLV_EN && intlv_i) begin
         mode_o.err      = 1'b1;
         mode_o.fullpage = 1'b0;
         mode_o.lg       = 2'd0;
      end
   end

endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             fullpage_i,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] beat_nxt_o,
   output logic             last_nxt_o
);

   logic [COL_W-1:0] beat_q;

   assign beat_nxt_o = beat_q + 1'b1;
   assign last_nxt_o = !fullpage_i && (beat_nxt_o == mask_i);
   assign beat_o     = beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (load_i) begin
         beat_q <= '0;
      end else if (adv_i) begin
         beat_q <= beat_nxt_o;
      end
   end

endmodule

// File: rtl/bcs_addr_step.sv
module bcs_addr_step #(
   parameter int unsigned COL_W    = 8,
   parameter bit          INTLV_EN = 1'b1
) (
   input  logic [COL_W-1:0] cur_col_i,
   input  logic [COL_W-1:0] base_col_i,
   input  logic [COL_W-1:0] beat_nxt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             intlv_i,
   output logic [COL_W-1:0] nxt_col_o
);

   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] alt_low;
   logic [COL_W-1:0] sel_low;

   assign seq_low = cur_col_i + 1'b1;

   generate
      if (INTLV_EN) begin : g_xor
         assign alt_low = base_col_i ^ beat_nxt_i;
         assign sel_low = intlv_i ? alt_low : seq_low;
      end else begin : g_inc
         assign alt_low = '0;
         assign sel_low = seq_low;
      end
   endgenerate

   // bits inside the burst block move, bits above it hold
   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign nxt_col_o[b] = mask_i[b] ? sel_low[b] : cur_col_i[b];
   end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int unsigned COL_W    = 8,
   parameter bit          INTLV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_start_i,
   input  logic [COL_W-1:0] req_col_i,
   input  logic             req_stop_i,
   input  logic [2:0]       cfg_len_i,
   input  logic             cfg_intlv_i,
   output logic [COL_W-1:0] seq_col_o,
   output logic             seq_valid_o,
   output logic             seq_last_o,
   output logic             cfg_err_o
);

   localparam int unsigned MAX_BLK = 1 << BCS_LG_MAX;

   generate
      if (COL_W < BCS_LG_MAX) begin : g_bad_width
         $error("burst_col_seq: COL_W must cover the largest bounded burst");
      end
      if ((1 << COL_W) < MAX_BLK) begin : g_bad_span
         $error("burst_col_seq: column space smaller than a burst block");
      end
   endgenerate

   bcs_mode_t        mode_new;
   logic [COL_W-1:0] mask_new;
   logic [COL_W-1:0] mask_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] col_q;
   logic             valid_q;
   logic             last_q;
   logic             err_q;
   logic             fp_q;
   logic             intlv_q;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] beat_nxt;
   logic             last_nxt;
   logic [COL_W-1:0] nxt_col;
   logic             advance;

   bcs_mode_dec #(
      .INTLV_EN (INTLV_EN)
   ) u_dec (
      .len_code_i (cfg_len_i),
      .intlv_i    (cfg_intlv_i),
      .mode_o     (mode_new)
   );

   assign mask_new = mode_new.fullpage ? {COL_W{1'b1}}
                                       : COL_W'((1 << mode_new.lg) - 1);

   assign advance = valid_q && !req_start_i && !req_stop_i && !last_q;

   bcs_beat_ctr #(
      .COL_W (COL_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (req_start_i),
      .adv_i      (advance),
      .mask_i     (mask_q),
      .fullpage_i (fp_q),
      .beat_o     (beat),
      .beat_nxt_o (beat_nxt),
      .last_nxt_o (last_nxt)
   );

   bcs_addr_step #(
      .COL_W    (COL_W),
      .INTLV_EN (INTLV_EN)
   ) u_step (
      .cur_col_i  (col_q),
      .base_col_i (base_q),
      .beat_nxt_i (beat_nxt),
      .mask_i     (mask_q),
      .intlv_i    (intlv_q),
      .nxt_col_o  (nxt_col)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         last_q  <= 1'b0;
         err_q   <= 1'b0;
         col_q   <= '0;
         base_q  <= '0;
         mask_q  <= '0;
         fp_q    <= 1'b0;
         intlv_q <= 1'b0;
      end else if (req_start_i) begin
         valid_q <= 1'b1;
         col_q   <= req_col_i;
         base_q  <= req_col_i;
         mask_q  <= mask_new;
         fp_q    <= mode_new.fullpage;
         intlv_q <= mode_new.intlv;
         err_q   <= mode_new.err;
         last_q  <= !mode_new.fullpage && (mask_new == '0);
      end else if (req_stop_i || (valid_q && last_q)) begin
         valid_q <= 1'b0;
         last_q  <= 1'b0;
      end else if (valid_q) begin
         col_q  <= nxt_col;
         last_q <= last_nxt;
      end
   end

   assign seq_col_o   = col_q;
   assign seq_valid_o = valid_q;
   assign seq_last_o  = last_q;
   assign cfg_err_o   = err_q;

   // ---------------------------------------------------------------
   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      req_start_i |=> seq_valid_o && (seq_col_o == $past(req_col_i)));  // R2

   AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      seq_valid_o && seq_last_o && !req_start_i |=> !seq_valid_o);  // R3

   AST_INTLV_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && intlv_q |-> (((col_q ^ base_q) & mask_q) == (beat & mask_q)));  // R5

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && !fp_q && $past(valid_q) && !$past(req_start_i)
      |-> (((col_q ^ $past(col_q)) & ~mask_q) == '0));  // R6

   AST_FP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && fp_q && $past(valid_q) && !$past(req_start_i)
      |-> (col_q == COL_W'($past(col_q) + 1'b1)));  // R7

   AST_FP_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && fp_q |-> !seq_last_o);  // R7

   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      req_stop_i && !req_start_i |=> !seq_valid_o);  // R8

   AST_RSV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_start_i && (cfg_len_i inside {3'b100, 3'b101, 3'b110})
      |=> seq_last_o && cfg_err_o);  // R10

endmodule

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_start_i = 1'b0;
   logic [7:0] req_col_i = '0;
   logic       req_stop_i = 1'b0;
   logic [2:0] cfg_len_i = '0;
   logic       cfg_intlv_i = 1'b0;
   logic [7:0] seq_col_o;
   logic       seq_valid_o;
   logic       seq_last_o;
   logic       cfg_err_o;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   burst_col_seq u_burst_col_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_start_i (req_start_i),
      .req_col_i   (req_col_i),
      .req_stop_i  (req_stop_i),
      .cfg_len_i   (cfg_len_i),
      .cfg_intlv_i (cfg_intlv_i),
      .seq_col_o   (seq_col_o),
      .seq_valid_o (seq_valid_o),
      .seq_last_o  (seq_last_o),
      .cfg_err_o   (cfg_err_o)
   );

   // reference model state
   logic       m_valid = 0, m_fp = 0, m_ty = 0, m_err = 0;
   int         m_beat = 0, m_len = 1;
   logic [7:0] m_start = '0;

   function automatic int len_of(input logic [2:0] c, input logic ty);
      case (c)
         3'b000: return 1;
         3'b001: return 2;
         3'b010: return 4;
         3'b011: return 8;
         3'b111: return ty ? 1 : 0;   // 0 = full page
         default: return 1;
      endcase
   endfunction

   function automatic logic [7:0] exp_col();
      int mask;
      int low;
      if (m_fp) return 8'((int'(m_start) + m_beat) % 256);
      mask = m_len - 1;
      low  = m_ty ? ((int'(m_start) & mask) ^ m_beat)
                  : (((int'(m_start) & mask) + m_beat) & mask);
      return 8'((int'(m_start) & ~mask) | low);
   endfunction

   task automatic model_edge(input logic s, input logic [7:0] sc, input logic st,
                             input logic [2:0] code, input logic ty);
      if (s) begin
         m_valid = 1; m_beat = 0; m_start = sc;
         m_len   = len_of(code, ty);
         m_fp    = (m_len == 0);
         m_err   = (code inside {3'b100, 3'b101, 3'b110}) || (code == 3'b111 && ty);
         m_ty    = ty && !m_err && !m_fp;
      end else if (st) begin
         m_valid = 0;
      end else if (m_valid) begin
         if (!m_fp && m_beat == m_len - 1) m_valid = 0;
         else m_beat++;
      end
   endtask

   task automatic dir(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      logic       e_last;
      logic [7:0] e_col;
      string      tag;
      e_last = m_valid && !m_fp && (m_beat == m_len - 1);
      e_col  = exp_col();
      tag = m_fp ? "R7" : (!m_valid ? "R3" : (m_ty ? "R5" : "R4"));
      checks++;
      if (seq_valid_o !== m_valid || seq_last_o !== e_last || cfg_err_o !== m_err ||
          (m_valid && seq_col_o !== e_col)) begin
         fails++;
         $display("FAIL %s actual v=%0b l=%0b e=%0b c=%0h expected v=%0b l=%0b e=%0b c=%0h",
                  tag, seq_valid_o, seq_last_o, cfg_err_o, seq_col_o,
                  m_valid, e_last, m_err, e_col);
      end
   endtask

   // one clock: drive at negedge, model at posedge, judge at next negedge
   task automatic cyc(input logic s, input logic [7:0] sc, input logic st,
                      input logic [2:0] code, input logic ty);
      req_start_i = s; req_col_i = sc; req_stop_i = st;
      cfg_len_i = code; cfg_intlv_i = ty;
      @(posedge clk);
      model_edge(s, sc, st, code, ty);
      @(negedge clk);
      req_start_i = 0; req_stop_i = 0;
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, cfg_len_i, cfg_intlv_i);
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      dir("R1 valid", seq_valid_o, 0);
      dir("R1 last",  seq_last_o,  0);
      dir("R1 err",   cfg_err_o,   0);
      dir("R1 col",   seq_col_o,   0);
      rst_n = 1;
      @(negedge clk);

      // R2 / R4 / R6: length 4 sequential, start 0x12
      cyc(1, 8'h12, 0, 3'b010, 0);
      dir("R2 start col", seq_col_o, 8'h12);
      cfg_len_i = 3'b011;           // change after start: no effect (R2)
      cyc(0, 0, 0, 3'b011, 1); dir("R4 beat1", seq_col_o, 8'h13);
      cyc(0, 0, 0, 3'b011, 1); dir("R4 beat2", seq_col_o, 8'h10);
      cyc(0, 0, 0, 3'b011, 1); dir("R6 beat3", seq_col_o, 8'h11);
      dir("R3 last", seq_last_o, 1);
      cyc(0, 0, 0, 3'b011, 1); dir("R3 end", seq_valid_o, 0);

      // R5: length 8 interleaved, start 0xA3
      cyc(1, 8'hA3, 0, 3'b011, 1); dir("R5 b0", seq_col_o, 8'hA3);
      cyc(0, 0, 0, 3'b011, 1);     dir("R5 b1", seq_col_o, 8'hA2);
      cyc(0, 0, 0, 3'b011, 1);     dir("R5 b2", seq_col_o, 8'hA1);
      cyc(0, 0, 0, 3'b011, 1);     dir("R5 b3", seq_col_o, 8'hA0);
      cyc(0, 0, 0, 3'b011, 1);     dir("R5 b4", seq_col_o, 8'hA7);
      idle(4);

      // R7: full page across the top of the column space, then R8 stop
      cyc(1, 8'hFE, 0, 3'b111, 0);
      cyc(0, 0, 0, 3'b111, 0); dir("R7 ff", seq_col_o, 8'hFF);
      cyc(0, 0, 0, 3'b111, 0); dir("R7 wrap", seq_col_o, 8'h00);
      dir("R7 no last", seq_last_o, 0);
      idle(300);
      cyc(0, 0, 1, 3'b111, 0); dir("R8 stop", seq_valid_o, 0);

      // R9: restart mid burst, then start with stop, then start on final beat
      cyc(1, 8'h40, 0, 3'b011, 0);
      cyc(0, 0, 0, 3'b011, 0);
      cyc(1, 8'h75, 0, 3'b001, 0); dir("R9 restart", seq_col_o, 8'h75);
      cyc(1, 8'h33, 1, 3'b010, 0); dir("R9 start beats stop", seq_valid_o, 1);
      dir("R9 col", seq_col_o, 8'h33);
      cyc(0, 0, 0, 3'b010, 0);
      cyc(0, 0, 0, 3'b010, 0);
      cyc(0, 0, 0, 3'b010, 0);     // final beat now shown
      cyc(1, 8'h08, 0, 3'b000, 0); dir("R9 start on last", seq_col_o, 8'h08);
      dir("R3 single last", seq_last_o, 1);

      // R10 undefined modes
      cyc(1, 8'h5C, 0, 3'b101, 0);
      dir("R10 err", cfg_err_o, 1);
      dir("R10 last", seq_last_o, 1);
      cyc(0, 0, 0, 3'b101, 0); dir("R10 one beat", seq_valid_o, 0);
      dir("R10 err held", cfg_err_o, 1);
      cyc(1, 8'h10, 0, 3'b111, 1); dir("R10 fp intlv", cfg_err_o, 1);
      cyc(1, 8'h10, 0, 3'b001, 0); dir("R10 cleared", cfg_err_o, 0);
      idle(3);

      // constrained random mix
      begin
         int unsigned seed = 32'h5EED_0042;
         void'($urandom(seed));
         for (int i = 0; i < 4000; i++) begin
            logic s, st, ty;
            logic [2:0] code;
            s    = ($urandom % 8) == 0;
            st   = ($urandom % 40) == 0;
            ty   = $urandom % 2;
            code = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 4);
            cyc(s, 8'($urandom), st, code, ty);
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule